// File: doc/BRIEF.md
# Framed Payload Output Interface (serial or nibble)

This block hands received frame payload to terminal equipment over one of two output paths. In bit-serial mode each accepted line bit is re-issued on a single data pin with an output strobe. In nibble mode four consecutive bits are packed onto a 4-bit bus and a strobe is issued once per nibble. A frame marker is raised together with the strobe that carries the first bit or the first nibble of every frame. The frame length in nibbles depends on the selected frame format.

Everything runs on one system clock. Line bits arrive as `bit_in` qualified by `bit_vld`, and `sof_in` flags the first bit of a frame. The external output clock is represented by the strobes. Serial data is refreshed on the output clock's rising edge and sampled by the far end on its falling edge. Nibble data uses the opposite pair of edges. An output stage outside this block turns the strobes into those edges. A change of mode or format waits for the next frame start. The block keeps an internal nibble counter and compares its wrap point with the incoming frame starts. Any disagreement sets a sticky error flag.

Top module: `pl_out_if`

## Requirements
- R1: While `rst_n` is low and immediately after it is released, `ser_stb`, `nib_stb`, `frm_mark`, `ser_dat`, `nib_dat` and `len_err` are all 0.
- R2: In serial mode (`mode_sel`=0), every bit accepted with `bit_vld`=1 appears on `ser_dat` with `ser_stb`=1 in the following cycle. `nib_stb` stays 0.
- R3: In serial mode, `frm_mark` is 1 exactly in the strobe cycle of the bit that was accepted with `sof_in`=1.
- R4: In nibble mode (`mode_sel`=1), `nib_stb` pulses for one cycle in the cycle after each fourth accepted bit, counted from the frame start. The first bit of a group of four is placed on `nib_dat[3]` and the last on `nib_dat[0]`. `ser_stb` stays 0.
- R5: In nibble mode, `frm_mark` is 1 only together with the strobe of the first nibble of each frame.
- R6: With `fmt_sel`=0 (DS3), the nibble counter wraps after 1176 nibbles. Back-to-back frames of that length raise no error and no extra frame marker.
- R7: With `fmt_sel`=1 (E3 G.832), the wrap point is 1074 nibbles.
- R8: With `fmt_sel`=2 (E3 G.751), the wrap point is 384 nibbles. Code 3 behaves the same as code 2.
- R9: If `mode_sel` or `fmt_sel` changes, no strobe and no marker is issued until the next accepted bit that carries `sof_in`=1. The new setting applies from that bit onward.
- R10: `len_err` becomes 1 and stays 1 until reset if, within a running frame sequence, a frame start arrives anywhere other than the counter's wrap point, or the wrap point passes without a frame start.
- R11: After reset, no strobe is issued until the first accepted bit with `sof_in`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_vld | input | 1 | Qualifies `bit_in` and `sof_in` in this cycle |
| bit_in | input | 1 | Received payload bit |
| sof_in | input | 1 | Marks the current bit as the first bit of a frame |
| mode_sel | input | 1 | 0 = bit-serial output, 1 = nibble output |
| fmt_sel | input | 2 | 0 = DS3, 1 = E3 G.832, 2 or 3 = E3 G.751 |
| ser_dat | output | 1 | Serial output data |
| ser_stb | output | 1 | Serial output clock enable, one per bit |
| nib_dat | output | 4 | Nibble output bus, earliest bit on bit 3 |
| nib_stb | output | 1 | Nibble output clock enable, one per nibble |
| frm_mark | output | 1 | Frame boundary marker, coincident with the first strobe of a frame |
| len_err | output | 1 | Sticky frame-length mismatch flag |

## Verification
Suppose the bit or nibble position counter drifts from the incoming frame starts. The block then emits a stray frame marker at the wrong wrap point within that same frame, and `len_err` rises on the bit where the next frame start should have matched. A wrong shift-register order or a wrong strobe phase corrupts the very next nibble on the bus. If the gating of active settings is wrong, strobes appear during the idle window after a mode or format change. Every strobe is therefore compared, one by one, against a queue of expected bits, nibbles and markers built from the driven stream.

// File: rtl/po_pkg.sv
package po_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned BW    = $clog2(NIB_W);

  localparam logic [1:0] FMT_DS3  = 2'd0;
  localparam logic [1:0] FMT_G832 = 2'd1;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/po_cfg_gate.sv
module po_cfg_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       sof,
  input  logic       mode_sel,
  input  logic [1:0] fmt_sel,
  output logic       live,
  output logic       cont
);
  logic       run_q, run_d;
  logic       mode_q, mode_d;
  logic [1:0] fmt_q, fmt_d;
  logic       same, start;

  always_comb begin
    same  = (mode_sel == mode_q) && (fmt_sel == fmt_q);
    start = bit_en && sof;
    live  = bit_en && (sof || (run_q && same));
    cont  = bit_en && run_q && same;
    run_d  = start ? 1'b1 : (run_q && same);
    mode_d = start ? mode_sel : mode_q;
    fmt_d  = start ? fmt_sel : fmt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      fmt_q  <= 2'd0;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
      fmt_q  <= fmt_d;
    end
  end

  // R9
  cfg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sof) |=> (run_q && mode_q == $past(mode_sel) && fmt_q == $past(fmt_sel)));
endmodule

// File: rtl/po_frame_cnt.sv
module po_frame_cnt
  import po_pkg::*;
#(
  parameter int unsigned DS3_NIB  = 1176,
  parameter int unsigned G832_NIB = 1074,
  parameter int unsigned G751_NIB = 384
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                live,
  input  logic                cont,
  input  logic                sof,
  input  logic [1:0]          fmt_sel,
  output logic [BW-1:0]       pos_bit,
  output logic                nib_first,
  output logic                len_err
);
  localparam int unsigned MAXN = max3(DS3_NIB, G832_NIB, G751_NIB);
  localparam int unsigned NW   = $clog2(MAXN);

  logic [BW-1:0] bcnt_q, bcnt_d;
  logic [NW-1:0] ncnt_q, ncnt_d, pos_nib, last;
  logic          err_q, err_d, at_wrap;

  always_comb begin
    case (fmt_sel)
      FMT_DS3:  last = NW'(DS3_NIB - 1);
      FMT_G832: last = NW'(G832_NIB - 1);
      default:  last = NW'(G751_NIB - 1);
    endcase
    pos_bit   = sof ? '0 : bcnt_q;
    pos_nib   = sof ? '0 : ncnt_q;
    nib_first = (pos_nib == '0);
    at_wrap   = (bcnt_q == '0) && (ncnt_q == '0);
    bcnt_d    = bcnt_q;
    ncnt_d    = ncnt_q;
    if (live) begin
      if (pos_bit == BW'(NIB_W - 1)) begin
        bcnt_d = '0;
        ncnt_d = (pos_nib == last) ? '0 : NW'(pos_nib + 1'b1);
      end else begin
        bcnt_d = BW'(pos_bit + 1'b1);
        ncnt_d = pos_nib;
      end
    end
    err_d = err_q | (cont & (sof ^ at_wrap));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      ncnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      bcnt_q <= bcnt_d;
      ncnt_q <= ncnt_d;
      err_q  <= err_d;
    end
  end

  assign len_err = err_q;

  // R6
  nib_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cont |-> (ncnt_q <= last));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/po_out_pack.sv
module po_out_pack
  import po_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             bit_in,
  input  logic             mode_sel,
  input  logic [BW-1:0]    pos_bit,
  input  logic             nib_first,
  output logic             ser_dat,
  output logic             ser_stb,
  output logic [NIB_W-1:0] nib_dat,
  output logic             nib_stb,
  output logic             frm_mark
);
  logic [NIB_W-2:0] sh_q, sh_d;
  logic             sd_q, sd_d, ss_q, ss_d, ns_q, ns_d, mk_q, mk_d;
  logic [NIB_W-1:0] nd_q, nd_d;
  logic             nib_end;

  always_comb begin
    nib_end = (pos_bit == BW'(NIB_W - 1));
    sh_d = live ? {sh_q[NIB_W-3:0], bit_in} : sh_q;
    ss_d = live && !mode_sel;
    ns_d = live && mode_sel && nib_end;
    sd_d = ss_d ? bit_in : sd_q;
    nd_d = ns_d ? {sh_q, bit_in} : nd_q;
    mk_d = live && nib_first && (mode_sel ? nib_end : (pos_bit == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
      ss_q <= 1'b0;
      ns_q <= 1'b0;
      nd_q <= '0;
      mk_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      sd_q <= sd_d;
      ss_q <= ss_d;
      ns_q <= ns_d;
      nd_q <= nd_d;
      mk_q <= mk_d;
    end
  end

  assign ser_dat  = sd_q;
  assign ser_stb  = ss_q;
  assign nib_dat  = nd_q;
  assign nib_stb  = ns_q;
  assign frm_mark = mk_q;

  // R2
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_q && ns_q));
  // R5
  mark_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mk_q |-> (ss_q || ns_q));
endmodule

// File: rtl/pl_out_if.sv
module pl_out_if
  import po_pkg::*;
#(
  parameter int unsigned DS3_NIB  = 1176,
  parameter int unsigned G832_NIB = 1074,
  parameter int unsigned G751_NIB = 384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             sof_in,
  input  logic             mode_sel,
  input  logic [1:0]       fmt_sel,
  output logic             ser_dat,
  output logic             ser_stb,
  output logic [NIB_W-1:0] nib_dat,
  output logic             nib_stb,
  output logic             frm_mark,
  output logic             len_err
);
  logic          live, cont, nib_first;
  logic [BW-1:0] pos_bit;

  po_cfg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_vld), .sof(sof_in),
    .mode_sel(mode_sel), .fmt_sel(fmt_sel), .live(live), .cont(cont)
  );

  po_frame_cnt #(.DS3_NIB(DS3_NIB), .G832_NIB(G832_NIB), .G751_NIB(G751_NIB)) u_cnt (
    .clk(clk), .rst_n(rst_n), .live(live), .cont(cont), .sof(sof_in),
    .fmt_sel(fmt_sel), .pos_bit(pos_bit), .nib_first(nib_first), .len_err(len_err)
  );

  po_out_pack u_pack (
    .clk(clk), .rst_n(rst_n), .live(live), .bit_in(bit_in), .mode_sel(mode_sel),
    .pos_bit(pos_bit), .nib_first(nib_first), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .nib_dat(nib_dat), .nib_stb(nib_stb), .frm_mark(frm_mark)
  );

  // R4
  nib_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |=> !nib_stb);
  // R2
  ser_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |-> $past(bit_vld));
endmodule

// File: tb/pl_out_if_test.sv
module pl_out_if_test;
  logic clk = 1'b0;
  logic rst_n;
  logic bit_vld, bit_in, sof_in, mode_sel;
  logic [1:0] fmt_sel;
  logic ser_dat, ser_stb, nib_stb, frm_mark, len_err;
  logic [3:0] nib_dat;

  always #5 clk = ~clk;

  pl_out_if uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .sof_in(sof_in),
    .mode_sel(mode_sel), .fmt_sel(fmt_sel), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .nib_dat(nib_dat), .nib_stb(nib_stb), .frm_mark(frm_mark), .len_err(len_err)
  );

  typedef struct packed { logic is_nib; logic [3:0] dat; logic mark; } item_t;
  item_t exp_q[$];

  int n_tests = 0;
  int n_fail  = 0;
  int stray   = 0;
  int k       = 0;
  int gap     = 0;
  logic [2:0]  bsh = 3'b0;
  logic [31:0] rs  = 32'h1234_5678;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(logic sof, bit push);
    logic b;
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    b = rs[0];
    @(posedge clk); #1;
    bit_vld = 1'b1; bit_in = b; sof_in = sof;
    if (sof) k = 0;
    if (push) begin
      if (!mode_sel) exp_q.push_back('{1'b0, {3'b000, b}, (k == 0)});
      else if (k % 4 == 3) exp_q.push_back('{1'b1, {bsh, b}, (k == 3)});
    end
    bsh = {bsh[1:0], b};
    k++;
    gap++;
    if (gap % 11 == 0) begin
      @(posedge clk); #1;
      bit_vld = 1'b0; bit_in = ~b; sof_in = 1'b1;   // sof without valid must be ignored
    end
  endtask

  task automatic send_frame(int nbits, bit with_sof, bit push);
    for (int i = 0; i < nbits; i++) send_bit(with_sof && (i == 0), push);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bit_vld = 1'b0; sof_in = 1'b0;
    end
  endtask

  task automatic set_cfg(logic m, logic [1:0] f);
    @(posedge clk); #1;
    bit_vld = 1'b0; sof_in = 1'b0; mode_sel = m; fmt_sel = f;
  endtask

  // monitor: pops one expected item per strobe
  always @(negedge clk) begin
    item_t e;
    if (rst_n && !done && (ser_stb || nib_stb)) begin
      if (exp_q.size() == 0) begin
        stray++;
        chk(1'b0, "R9/R11 unexpected strobe", 1, 0);
      end else begin
        e = exp_q.pop_front();
        if (e.is_nib) begin
          chk(nib_stb && !ser_stb, "R4 nibble strobe only", int'(nib_stb), 1);
          chk(nib_dat == e.dat, "R4 nibble data", int'(nib_dat), int'(e.dat));
          chk(frm_mark == e.mark, "R5 nibble marker (length R6/R7/R8)", int'(frm_mark), int'(e.mark));
        end else begin
          chk(ser_stb && !nib_stb, "R2 serial strobe only", int'(ser_stb), 1);
          chk(ser_dat == e.dat[0], "R2 serial data", int'(ser_dat), int'(e.dat[0]));
          chk(frm_mark == e.mark, "R3 serial marker", int'(frm_mark), int'(e.mark));
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int s0;
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; sof_in = 1'b0;
    mode_sel = 1'b1; fmt_sel = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    chk({ser_stb, nib_stb, frm_mark, ser_dat, nib_dat, len_err} == 9'd0, "R1 reset outputs",
        int'({ser_stb, nib_stb, frm_mark, ser_dat, nib_dat, len_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ser_stb, nib_stb, frm_mark, len_err} == 4'd0, "R1 after release",
        int'({ser_stb, nib_stb, frm_mark, len_err}), 0);

    // R11: no output before the first frame start
    s0 = stray;
    send_frame(20, 1'b0, 1'b0);
    idle(3);
    chk(stray == s0, "R11 idle before first start", stray - s0, 0);

    // nibble mode, all three formats
    send_frame(4704, 1'b1, 1'b1);
    send_frame(4704, 1'b1, 1'b1);
    send_frame(4, 1'b1, 1'b1);
    idle(3);
    chk(len_err == 1'b0, "R6 DS3 wrap matches frame", int'(len_err), 0);
    set_cfg(1'b1, 2'd1);
    send_frame(4296, 1'b1, 1'b1);
    send_frame(4296, 1'b1, 1'b1);
    send_frame(4, 1'b1, 1'b1);
    idle(3);
    chk(len_err == 1'b0, "R7 G.832 wrap matches frame", int'(len_err), 0);
    set_cfg(1'b1, 2'd2);
    send_frame(1536, 1'b1, 1'b1);
    send_frame(1536, 1'b1, 1'b1);
    send_frame(1536, 1'b1, 1'b1);
    idle(3);
    chk(len_err == 1'b0, "R8 G.751 wrap matches frame", int'(len_err), 0);
    chk(exp_q.size() == 0, "R4 all nibbles delivered", exp_q.size(), 0);

    // R9: mode change mid-frame, idle until next start
    set_cfg(1'b0, 2'd2);
    s0 = stray;
    send_frame(100, 1'b0, 1'b0);
    idle(2);
    chk(stray == s0, "R9 idle after mode change", stray - s0, 0);
    send_frame(1536, 1'b1, 1'b1);
    send_frame(1536, 1'b1, 1'b1);
    set_cfg(1'b0, 2'd0);
    s0 = stray;
    send_frame(40, 1'b0, 1'b0);
    idle(2);
    chk(stray == s0, "R9 idle after format change", stray - s0, 0);
    send_frame(4704, 1'b1, 1'b1);
    send_frame(8, 1'b1, 1'b1);
    idle(3);
    chk(exp_q.size() == 0, "R2 all serial bits delivered", exp_q.size(), 0);
    chk(len_err == 1'b0, "R6 serial DS3 wrap matches frame", int'(len_err), 0);

    // R10: short frame
    set_cfg(1'b1, 2'd2);
    send_frame(1536, 1'b1, 1'b1);
    send_frame(1536, 1'b1, 1'b1);
    send_frame(800, 1'b1, 1'b1);
    idle(2);
    chk(len_err == 1'b0, "R10 no error before mismatch", int'(len_err), 0);
    send_frame(1536, 1'b1, 1'b1);
    idle(2);
    chk(len_err == 1'b1, "R10 early start flagged", int'(len_err), 1);
    send_frame(1536, 1'b1, 1'b1);
    send_frame(4, 1'b1, 1'b1);
    idle(3);
    chk(len_err == 1'b1, "R10 flag sticky", int'(len_err), 1);
    chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule